// File: doc/BRIEF.md
# Debug Vector Catch Unit

This block holds a 64-bit debug configuration register made of per-exception catch enables. It watches the instruction fetch stream and raises a one-cycle debug event when a valid fetch lands on an enabled slot of the exception vector table. The vector table starts at a base address supplied as an input. Each slot is identified by its byte offset from that base. The event carries a 3-bit exception-type code and a flag that tells which security bank supplied the enable.

A build parameter says whether the system has a secure-monitor level. With that level present, the register holds two banks of enables: the secure bank sits in the low byte and the non-secure bank sits in bits 31 down to 25. The current security state picks the bank. Without the monitor level, only the low-byte bank exists and the security state input is not used. Reserved positions ignore writes, so they always read as zero. The enables have no defined value after a warm reset. A parameter selects either an unreset register or a clear to zero on reset, which suits simulation.

Top module: `vcatch_unit`

## Requirements
- R1: With the reset-clear option on (the default), reset leaves the read data at zero and the catch outputs at zero.
- R2: A write stores the data masked to the writable positions, and the new value appears on the read data in the cycle after the write edge.
- R3: With the monitor level present, the writable positions are bits 1, 2, 3, 4, 6 and 7 for the secure bank and bits 25, 26, 27, 28, 30 and 31 for the non-secure bank (mask 0x00000000_DE0000DE). Every other bit ignores writes and reads as zero.
- R4: Without the monitor level, only bits 1, 2, 3, 4, 6 and 7 are writable (mask 0xDE). Bits 63 to 8, bit 5 and bit 0 read as zero.
- R5: A fetch that matches a slot reports the exception-type code equal to the slot offset divided by four. The codes are: 0x04 undefined instruction = 1, 0x08 supervisor call = 2, 0x0C prefetch abort = 3, 0x10 data abort = 4, 0x18 IRQ = 6, 0x1C FIQ = 7.
- R6: A catch needs the enable for that code in the selected bank. The secure bank uses bit number code. The non-secure bank uses bit number 24 + code. With the monitor level present, secure state (sec_state = 1) selects the secure bank and non-secure state selects the non-secure bank.
- R7: Offsets 0x00 and 0x14, offsets that are not a multiple of four, and addresses outside base to base+0x1C never produce a catch. Offsets are taken modulo 2^ADDR_W.
- R8: The catch outputs are registered. A valid matching fetch sampled on one clock edge shows on the outputs for exactly the following cycle. Without a valid fetch the outputs return to zero, and when catch_valid is low the type and security outputs are zero.
- R9: catch_secure is 1 when the secure bank supplied the enable. Without the monitor level, sec_state has no effect and catch_secure is always 0.
- R10: A fetch sampled on the same edge as a write is judged against the register value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 64 | Register write data |
| cfg_rdata | output | 64 | Current register contents |
| fetch_valid | input | 1 | Instruction fetch strobe |
| fetch_addr | input | ADDR_W | Fetch address |
| vec_base | input | ADDR_W | Exception vector table base |
| sec_state | input | 1 | Current security state, 1 = secure |
| catch_valid | output | 1 | One-cycle debug catch event |
| catch_kind | output | 3 | Exception-type code of the catch |
| catch_secure | output | 1 | Catch came from the secure bank |

## Verification
The bench aims at the two unused slots 0x00 and 0x14, at misaligned and out-of-window addresses, and at a vector base near the top of the address space where the offset wraps. A design that got these wrong would raise spurious catches or report the wrong code. It writes all-ones to a build with the monitor and to a build without it. A mask taken from the wrong build leaks reserved bits into the read data. It drives each slot in both security states with only one bank enabled. A swapped or wrongly offset bank index catches in the wrong state. It also places a fetch on the same edge as a write: a design that bypasses the new value would catch a cycle early.

// File: rtl/vcatch_pkg.sv
package vcatch_pkg;

    localparam int REG_W     = 64;
    localparam int KIND_W    = 3;
    localparam int NS_SHIFT  = 24;
    localparam int SLOT_SPAN = 32;

    typedef enum logic [KIND_W-1:0] {
        VK_NONE  = 3'd0,
        VK_UNDEF = 3'd1,
        VK_SVC   = 3'd2,
        VK_PABT  = 3'd3,
        VK_DABT  = 3'd4,
        VK_HOLE  = 3'd5,
        VK_IRQ   = 3'd6,
        VK_FIQ   = 3'd7
    } vk_kind_e;

    typedef struct packed {
        logic     valid;
        vk_kind_e kind;
        logic     secure;
    } vk_event_t;

    localparam logic [7:0] BANK_BYTE = 8'hDE;

    function automatic logic [REG_W-1:0] writable_mask(input bit has_monitor);
        logic [REG_W-1:0] m;
        m = '0;
        m[7:0] = BANK_BYTE;
        if (has_monitor) begin
            m[NS_SHIFT +: 8] = BANK_BYTE;
        end
        return m;
    endfunction

    function automatic logic is_vector_kind(input vk_kind_e k);
        return (k != VK_NONE) && (k != VK_HOLE);
    endfunction

endpackage

// File: rtl/vcatch_regfile.sv
module vcatch_regfile
    import vcatch_pkg::*;
#(
    parameter bit HAS_MONITOR   = 1'b1,
    parameter bit RESET_ENABLES = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] enables
);

    localparam logic [REG_W-1:0] KEEP = writable_mask(HAS_MONITOR);

    logic [REG_W-1:0] store_q;
    logic [REG_W-1:0] store_d;

    always_comb begin
        store_d = store_q;
        if (wr_en) begin
            store_d = wr_data & KEEP;
        end
    end

    generate
        if (RESET_ENABLES) begin : g_clear
            always_ff @(posedge clk) begin
                if (rst) begin
                    store_q <= '0;
                end else begin
                    store_q <= store_d;
                end
            end
        end else begin : g_raw
            always_ff @(posedge clk) begin
                store_q <= store_d;
            end
        end
    endgenerate

    assign enables = store_q;

    AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((enables & ~KEEP) == '0)); // R3
    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(enables)); // R2

endmodule

// File: rtl/vcatch_slot_decode.sv
module vcatch_slot_decode
    import vcatch_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [ADDR_W-1:0] vec_base,
    output logic              slot_hit,
    output vk_kind_e          slot_kind
);

    localparam int SPAN_BITS = $clog2(SLOT_SPAN);

    logic [ADDR_W-1:0] delta;
    logic              in_window;
    logic              aligned;

    always_comb begin
        delta     = fetch_addr - vec_base;
        in_window = (delta[ADDR_W-1:SPAN_BITS] == '0);
        aligned   = (delta[1:0] == 2'b00);
        slot_kind = vk_kind_e'(delta[SPAN_BITS-1:2]);
        slot_hit  = in_window && aligned && is_vector_kind(slot_kind);
    end

endmodule

// File: rtl/vcatch_event.sv
module vcatch_event
    import vcatch_pkg::*;
#(
    parameter bit HAS_MONITOR = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fetch_valid,
    input  logic             slot_hit,
    input  vk_kind_e         slot_kind,
    input  logic             sec_state,
    input  logic [REG_W-1:0] enables,
    output vk_event_t        evt
);

    localparam int IDX_W = $clog2(REG_W);

    logic [IDX_W-1:0] bit_idx;
    logic             use_secure;
    vk_event_t        evt_d;
    vk_event_t        evt_q;

    generate
        if (HAS_MONITOR) begin : g_banked
            always_comb begin
                use_secure = sec_state;
                if (sec_state) begin
                    bit_idx = IDX_W'(slot_kind);
                end else begin
                    bit_idx = IDX_W'(slot_kind) + IDX_W'(NS_SHIFT);
                end
            end
        end else begin : g_flat
            always_comb begin
                use_secure = 1'b0;
                bit_idx    = IDX_W'(slot_kind);
            end
        end
    endgenerate

    always_comb begin
        evt_d = '0;
        if (fetch_valid && slot_hit && enables[bit_idx]) begin
            evt_d.valid  = 1'b1;
            evt_d.kind   = slot_kind;
            evt_d.secure = HAS_MONITOR ? use_secure : 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= '0;
        end else begin
            evt_q <= evt_d;
        end
    end

    assign evt = evt_q;

    AST_CATCH_NEEDS_FETCH: assert property (@(posedge clk) disable iff (rst)
        evt_q.valid |-> $past(fetch_valid)); // R8
    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (rst)
        evt_q.valid |-> (evt_q.kind != VK_NONE && evt_q.kind != VK_HOLE)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !evt_q.valid |-> (evt_q.kind == VK_NONE && !evt_q.secure)); // R8
    AST_SECURE_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (evt_q.valid && evt_q.secure) |-> (($past(enables) >> evt_q.kind) & 64'd1) != 64'd0); // R6

    generate
        if (!HAS_MONITOR) begin : g_flat_chk
            AST_FLAT_NONSECURE: assert property (@(posedge clk) disable iff (rst)
                evt_q.valid |-> !evt_q.secure); // R9
        end
    endgenerate

endmodule

// File: rtl/vcatch_unit.sv
module vcatch_unit
    import vcatch_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter bit HAS_MONITOR   = 1'b1,
    parameter bit RESET_ENABLES = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [63:0]       cfg_wdata,
    output logic [63:0]       cfg_rdata,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [ADDR_W-1:0] vec_base,
    input  logic              sec_state,
    output logic              catch_valid,
    output logic [2:0]        catch_kind,
    output logic              catch_secure
);

    logic [REG_W-1:0] enables;
    logic             slot_hit;
    vk_kind_e         slot_kind;
    vk_event_t        evt;

    vcatch_regfile #(
        .HAS_MONITOR  (HAS_MONITOR),
        .RESET_ENABLES(RESET_ENABLES)
    ) u_regfile (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_we),
        .wr_data(cfg_wdata),
        .enables(enables)
    );

    vcatch_slot_decode #(
        .ADDR_W(ADDR_W)
    ) u_decode (
        .fetch_addr(fetch_addr),
        .vec_base  (vec_base),
        .slot_hit  (slot_hit),
        .slot_kind (slot_kind)
    );

    vcatch_event #(
        .HAS_MONITOR(HAS_MONITOR)
    ) u_event (
        .clk        (clk),
        .rst        (rst),
        .fetch_valid(fetch_valid),
        .slot_hit   (slot_hit),
        .slot_kind  (slot_kind),
        .sec_state  (sec_state),
        .enables    (enables),
        .evt        (evt)
    );

    assign cfg_rdata    = enables;
    assign catch_valid  = evt.valid;
    assign catch_kind   = evt.kind;
    assign catch_secure = evt.secure;

    AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (catch_valid && !$past(fetch_valid, 1)) |-> 1'b0); // R8
    AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> ((cfg_rdata & ~$past(cfg_wdata)) == '0)); // R2

endmodule

// File: tb/vcatch_unit_bench.sv
module vcatch_unit_bench;

    localparam int AW = 32;
    localparam logic [63:0] MASK_MON  = 64'h0000_0000_DE00_00DE;
    localparam logic [63:0] MASK_FLAT = 64'h0000_0000_0000_00DE;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [63:0]   cfg_wdata = '0;
    logic          fetch_valid = 1'b0;
    logic [AW-1:0] fetch_addr = '0;
    logic [AW-1:0] vec_base = '0;
    logic          sec_state = 1'b0;

    logic [63:0]   rd_m, rd_f;
    logic          cv_m, cv_f, cs_m, cs_f;
    logic [2:0]    ck_m, ck_f;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [63:0] model_m = '0;
    logic [63:0] model_f = '0;

    always #2 clk = ~clk;

    vcatch_unit #(.ADDR_W(AW), .HAS_MONITOR(1'b1)) u_vcatch_unit (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(rd_m),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .vec_base(vec_base),
        .sec_state(sec_state), .catch_valid(cv_m), .catch_kind(ck_m), .catch_secure(cs_m)
    );

    vcatch_unit #(.ADDR_W(AW), .HAS_MONITOR(1'b0)) u_vcatch_unit_flat (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(rd_f),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .vec_base(vec_base),
        .sec_state(sec_state), .catch_valid(cv_f), .catch_kind(ck_f), .catch_secure(cs_f)
    );

    function automatic logic [4:0] exp_catch(input bit mon, input logic [63:0] regv,
                                             input bit fv, input logic [AW-1:0] fa,
                                             input logic [AW-1:0] vb, input bit sec);
        logic [AW-1:0] d;
        int code;
        int idx;
        d = fa - vb;
        if (!fv || d >= 32 || d[1:0] != 2'b00) return 5'd0;
        code = int'(d[4:2]);
        if (code == 0 || code == 5) return 5'd0;
        idx = (mon && !sec) ? 24 + code : code;
        if (!regv[idx]) return 5'd0;
        return {1'b1, 3'(code), (mon ? sec : 1'b0)};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cycle(input bit we, input logic [63:0] wd, input bit fv,
                         input logic [AW-1:0] fa, input logic [AW-1:0] vb,
                         input bit sec, input string tag);
        logic [4:0] em, ef;
        cfg_we = we; cfg_wdata = wd; fetch_valid = fv;
        fetch_addr = fa; vec_base = vb; sec_state = sec;
        em = exp_catch(1'b1, model_m, fv, fa, vb, sec);
        ef = exp_catch(1'b0, model_f, fv, fa, vb, sec);
        @(posedge clk);
        if (we) begin
            model_m = wd & MASK_MON;
            model_f = wd & MASK_FLAT;
        end
        @(negedge clk);
        check({tag, " catch mon"}, 64'({cv_m, ck_m, cs_m}), 64'(em));
        check({tag, " catch flat"}, 64'({cv_f, ck_f, cs_f}), 64'(ef));
        check("R2 rdata mon", rd_m, model_m);
        check("R2 rdata flat", rd_f, model_f);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] base;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset rdata mon", rd_m, 64'd0);
        check("R1 reset rdata flat", rd_f, 64'd0);
        check("R1 reset catch", 64'({cv_m, ck_m, cs_m, cv_f, ck_f, cs_f}), 64'd0);

        // R3 / R4: all-ones write, reserved positions read zero
        cycle(1'b1, '1, 1'b0, '0, '0, 1'b0, "R3");
        check("R3 mask mon", rd_m, MASK_MON);
        check("R4 mask flat", rd_f, MASK_FLAT);

        // R5 / R7: sweep every offset, both states, everything enabled
        base = 32'h0000_1000;
        for (int s = 0; s < 2; s++) begin
            for (int off = 0; off < 40; off += 4) begin
                cycle(1'b0, '0, 1'b1, base + AW'(off), base, s[0], "R5_R7");
            end
        end

        // R8: idle cycle after a catch returns low
        cycle(1'b0, '0, 1'b1, base + 32'h1C, base, 1'b1, "R5");
        cycle(1'b0, '0, 1'b0, base + 32'h1C, base, 1'b1, "R8");
        check("R8 idle after catch", 64'({cv_m, ck_m, cs_m}), 64'd0);

        // R7: misaligned offsets and wrap near the top
        cycle(1'b0, '0, 1'b1, base + 32'h05, base, 1'b1, "R7");
        cycle(1'b0, '0, 1'b1, base - 32'h4, base, 1'b1, "R7");
        cycle(1'b0, '0, 1'b1, 32'h0000_0008, 32'hFFFF_FFF8, 1'b0, "R7");

        // R6 / R9: only non-secure bank enabled
        cycle(1'b1, 64'h0000_0000_DE00_0000, 1'b0, '0, '0, 1'b0, "R6");
        for (int s = 0; s < 2; s++) begin
            cycle(1'b0, '0, 1'b1, base + 32'h10, base, s[0], "R6_R9");
        end
        // only secure bank enabled
        cycle(1'b1, 64'h0000_0000_0000_00DE, 1'b0, '0, '0, 1'b0, "R6");
        for (int s = 0; s < 2; s++) begin
            cycle(1'b0, '0, 1'b1, base + 32'h18, base, s[0], "R6_R9");
        end

        // R10: fetch on the write edge uses old value (all clear before)
        cycle(1'b1, '0, 1'b0, '0, '0, 1'b0, "R10");
        cycle(1'b1, '1, 1'b1, base + 32'h04, base, 1'b1, "R10");
        check("R10 same-edge no catch", 64'({cv_m, cv_f}), 64'd0);
        cycle(1'b0, '0, 1'b1, base + 32'h04, base, 1'b1, "R10");
        check("R10 next-cycle catch", 64'({cv_m, ck_m, cs_m}), 64'b1_001_1);

        // constrained random
        for (int n = 0; n < 3000; n++) begin
            logic [AW-1:0] b, a;
            int pick;
            b = $urandom;
            pick = int'($urandom % 10);
            if (pick < 6)       a = b + AW'(($urandom % 10) * 4);
            else if (pick < 8)  a = b + AW'($urandom % 40);
            else                a = $urandom;
            cycle(($urandom % 8) == 0, {$urandom, $urandom}, ($urandom % 4) != 0,
                  a, b, $urandom % 2 == 1, "R6_rand");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule